// File: doc/BRIEF.md
# Egress Timestamp Queue

This block sits next to the transmit path of a time-aware Ethernet port. Each time an event frame leaves the port, a one-cycle capture strobe hands the block the low seconds bits and the nanoseconds of the departure time. The strobe also carries the frame's domain number, message type and sequence ID. The block stores these records in a small first-in-first-out queue so that software can later pair each timestamp with the frame it sent.

Software reaches the queue through a 16-bit register port with a 3-bit address. Four read-only data words show one record at a time, and a ring-control write steps to the next one. Every record carries a valid flag. Software keeps writing the step command and reading until that flag comes back clear. An interrupt line is high while the queue holds unread records and an enable bit allows it. Draining the queue is the only way to clear it, so no acknowledge exists.

Top module: `ptp_egress_ts_fifo`

## Requirements
- R1: After reset the queue is empty. All eight register addresses read 0, and irqOut is low.
- R2: Data word 0 (address 0) holds the domain number in bits 7:0, the message type in bits 11:8, seconds bits 4:2 in bits 14:12, and the valid flag in bit 15.
- R3: Data word 1 (address 1) holds the 16-bit sequence ID. Data word 2 (address 2) holds nanoseconds 15:0.
- R4: Data word 3 (address 3) holds nanoseconds 29:16 in bits 13:0 and seconds bits 1:0 in bits 15:14.
- R5: Writing address 4 with bit 0 set is a step command. On a non-empty queue it moves the oldest record into the data words with the valid flag set, visible from the next cycle. Records come out in capture order.
- R6: A step command on an empty queue clears all four data words to 0, so the valid flag reads 0. A write to address 4 with bit 0 clear changes nothing.
- R7: The queue holds DEPTH records (8 by default). A capture while full, without a step command in the same cycle, is dropped: the stored records are unchanged. The drop sets an overflow flag, read as bit 0 of address 7.
- R8: The overflow flag stays set until a write to address 7 with bit 0 set clears it. A new drop in the same cycle as the clear leaves the flag set.
- R9: A capture and a step command in the same cycle both take effect. This holds when the queue is full, where no overflow occurs, and when it is empty, where the data words clear and the new record is kept.
- R10: Address 6 bit 0 reads 1 whenever the queue is non-empty. irqOut equals that status ANDed with the enable bit at address 5 bit 0. irqOut stays high without any acknowledge until step commands empty the queue.
- R11: Address 5 reads back the enable bit in bit 0, and address 4 reads 0. Unused bits of addresses 4 to 7 read 0. Writes to addresses 0 to 3 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capValid | input | 1 | One-cycle capture strobe for a departing event frame |
| capSecLow | input | 5 | Seconds bits 4:0 of the departure time |
| capNsec | input | 30 | Nanoseconds of the departure time |
| capDomain | input | 8 | Domain number of the frame |
| capMsgType | input | 4 | Message type of the frame |
| capSeqId | input | 16 | Sequence ID of the frame |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| irqOut | output | 1 | Level interrupt: queue non-empty and enabled |

## Verification
The assertions treat every capValid cycle and every write to address 4 as a separate event. They do not assume any spacing between capture strobes and step commands, and they assume no relation between them. They also rely on regWrEn and regAddr being sampled at the same edge as the capture strobe, so a same-cycle capture and step is a defined case and not a hazard. The stimulus drives all inputs a fixed delay after each rising edge. Its directed phases push the queue to full and beyond and step it on empty, with both events in one cycle at each extreme. A long random phase then mixes captures, steps, enable changes, overflow clears and writes to read-only addresses, and a queue-based model checks the read data and the interrupt on every clock.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  localparam int DOMAIN_W = 8;
  localparam int MSGT_W   = 4;
  localparam int SEQ_W    = 16;
  localparam int NSEC_W   = 30;
  localparam int SEC_KEEP = 5;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_DATA = 4;

  localparam logic [ADDR_W-1:0] A_DATA0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA3 = 3'd3;
  localparam logic [ADDR_W-1:0] A_STEP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IRQEN = 3'd5;
  localparam logic [ADDR_W-1:0] A_IRQST = 3'd6;
  localparam logic [ADDR_W-1:0] A_OVF   = 3'd7;

  typedef struct packed {
    logic [DOMAIN_W-1:0] domain;
    logic [MSGT_W-1:0]   msgType;
    logic [SEQ_W-1:0]    seqId;
    logic [NSEC_W-1:0]   nsec;
    logic [SEC_KEEP-1:0] secLow;
  } tsEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clearView;
  } fifoCmd_t;

endpackage

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capValid,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [CNT_W-1:0]  fillCount,
  output fifoCmd_t          cmd,
  output logic              irqEn,
  output logic              ovfFlag
);

  logic stepCmd;
  logic isEmpty;
  logic isFull;
  logic dropCap;
  logic ovfClear;
  logic enWrite;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:1];

  assign isEmpty  = (fillCount == '0);
  assign isFull   = (fillCount == CNT_W'(DEPTH));
  assign stepCmd  = regWrEn && (regAddr == A_STEP) && regWrData[0];
  assign ovfClear = regWrEn && (regAddr == A_OVF) && regWrData[0];
  assign enWrite  = regWrEn && (regAddr == A_IRQEN);

  // A step on a full queue frees a slot in the same cycle
  assign dropCap = capValid && isFull && !stepCmd;

  always_comb begin
    cmd           = '0;
    cmd.pop       = stepCmd && !isEmpty;
    cmd.clearView = stepCmd && isEmpty;
    cmd.push      = capValid && !dropCap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (enWrite) begin
        irqEn <= regWrData[0];
      end
      if (dropCap) begin
        ovfFlag <= 1'b1;
      end else if (ovfClear) begin
        ovfFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tsq_datapath.sv
module tsq_datapath
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fifoCmd_t                      cmd,
  input  tsEntry_t                      capEntry,
  output logic [CNT_W-1:0]              fillCount,
  output logic                          viewValid,
  output logic [NUM_DATA-1:0][REG_W-1:0] dataWords
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  tsEntry_t         store [DEPTH];
  tsEntry_t         viewEntry;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // Storage array carries no reset; only pointers and count do
  always_ff @(posedge clk) begin
    if (cmd.push) begin
      store[wrPtr] <= capEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (cmd.push) begin
        wrPtr <= nextPtr(wrPtr);
      end
      if (cmd.pop) begin
        rdPtr <= nextPtr(rdPtr);
      end
      case ({cmd.push, cmd.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // Presented record, loaded by a step command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      viewEntry <= '0;
      viewValid <= 1'b0;
    end else if (cmd.pop) begin
      viewEntry <= store[rdPtr];
      viewValid <= 1'b1;
    end else if (cmd.clearView) begin
      viewEntry <= '0;
      viewValid <= 1'b0;
    end
  end

  // Seconds are split: high bits beside the header, low bits beside nsec
  always_comb begin
    dataWords[0] = {viewValid, viewEntry.secLow[4:2], viewEntry.msgType, viewEntry.domain};
    dataWords[1] = viewEntry.seqId;
    dataWords[2] = viewEntry.nsec[15:0];
    dataWords[3] = {viewEntry.secLow[1:0], viewEntry.nsec[29:16]};
  end

endmodule

// File: rtl/ptp_egress_ts_fifo.sv
module ptp_egress_ts_fifo
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                capValid,
  input  logic [SEC_KEEP-1:0] capSecLow,
  input  logic [NSEC_W-1:0]   capNsec,
  input  logic [DOMAIN_W-1:0] capDomain,
  input  logic [MSGT_W-1:0]   capMsgType,
  input  logic [SEQ_W-1:0]    capSeqId,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                irqOut
);

  fifoCmd_t                      cmd;
  tsEntry_t                      capEntry;
  logic [CNT_W-1:0]              fillCount;
  logic                          viewValid;
  logic                          irqEn;
  logic                          ovfFlag;
  logic                          pending;
  logic [NUM_DATA-1:0][REG_W-1:0] dataWords;

  always_comb begin
    capEntry         = '0;
    capEntry.domain  = capDomain;
    capEntry.msgType = capMsgType;
    capEntry.seqId   = capSeqId;
    capEntry.nsec    = capNsec;
    capEntry.secLow  = capSecLow;
  end

  tsq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .capValid  (capValid),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .fillCount (fillCount),
    .cmd       (cmd),
    .irqEn     (irqEn),
    .ovfFlag   (ovfFlag)
  );

  tsq_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .capEntry  (capEntry),
    .fillCount (fillCount),
    .viewValid (viewValid),
    .dataWords (dataWords)
  );

  assign pending = (fillCount != '0);
  assign irqOut  = pending && irqEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_DATA0: regRdData = dataWords[0];
      A_DATA1: regRdData = dataWords[1];
      A_DATA2: regRdData = dataWords[2];
      A_DATA3: regRdData = dataWords[3];
      A_IRQEN: regRdData[0] = irqEn;
      A_IRQST: regRdData[0] = pending;
      A_OVF:   regRdData[0] = ovfFlag;
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker
  import tsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              capValid,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic              irqOut,
  input logic [CNT_W-1:0]  fillCount,
  input logic              viewValid,
  input logic              ovfFlag
);

  logic stepW;
  logic clrW;
  logic enW;
  logic full;

  assign stepW = regWrEn && (regAddr == A_STEP) && regWrData[0];
  assign clrW  = regWrEn && (regAddr == A_OVF) && regWrData[0];
  assign enW   = regWrEn && (regAddr == A_IRQEN);
  assign full  = (fillCount == CNT_W'(DEPTH));

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH)); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    capValid && full && !stepW |=> full && ovfFlag); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !clrW |=> ovfFlag); // R8

  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    capValid && stepW && (fillCount != '0) |=> $stable(fillCount)); // R9

  AST_STEP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stepW && (fillCount != '0) |=> viewValid); // R5

  AST_STEP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stepW && (fillCount == '0) |=> !viewValid); // R6

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (fillCount != '0)); // R10

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !stepW && !enW |=> irqOut); // R10

endmodule

bind ptp_egress_ts_fifo tsq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .capValid  (capValid),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .irqOut    (irqOut),
  .fillCount (fillCount),
  .viewValid (viewValid),
  .ovfFlag   (ovfFlag)
);

// File: tb/tb_ptp_egress_ts_fifo.sv
module tb_ptp_egress_ts_fifo;

  localparam int DEPTH = 8;

  typedef struct packed {
    logic [7:0]  dom;
    logic [3:0]  msg;
    logic [15:0] seq;
    logic [29:0] ns;
    logic [4:0]  sec;
  } tbEnt_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        capValid;
  logic [4:0]  capSecLow;
  logic [29:0] capNsec;
  logic [7:0]  capDomain;
  logic [3:0]  capMsgType;
  logic [15:0] capSeqId;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ptp_egress_ts_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .capValid(capValid), .capSecLow(capSecLow),
    .capNsec(capNsec), .capDomain(capDomain), .capMsgType(capMsgType),
    .capSeqId(capSeqId), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // Behavioural reference model
  tbEnt_t mq[$];
  tbEnt_t mView;
  bit     mValid;
  bit     mEn;
  bit     mOvf;

  always @(posedge clk) begin
    bit stepNow;
    tbEnt_t e;
    if (!rstN) begin
      mq.delete();
      mView = '0; mValid = 0; mEn = 0; mOvf = 0;
    end else begin
      stepNow = regWrEn && regAddr == 3'd4 && regWrData[0];
      if (regWrEn && regAddr == 3'd5) mEn = regWrData[0];
      if (regWrEn && regAddr == 3'd7 && regWrData[0]) mOvf = 0;
      if (stepNow) begin
        if (mq.size() > 0) begin mView = mq.pop_front(); mValid = 1; end
        else begin mView = '0; mValid = 0; end
      end
      if (capValid) begin
        e = '{dom: capDomain, msg: capMsgType, seq: capSeqId, ns: capNsec, sec: capSecLow};
        if (mq.size() < DEPTH) mq.push_back(e);
        else mOvf = 1;
      end
    end
  end

  function automatic logic [15:0] modelWord(input logic [2:0] a);
    case (a)
      3'd0: return {mValid, mView.sec[4:2], mView.msg, mView.dom};
      3'd1: return mView.seq;
      3'd2: return mView.ns[15:0];
      3'd3: return {mView.sec[1:0], mView.ns[29:16]};
      3'd5: return {15'd0, mEn};
      3'd6: return {15'd0, mq.size() > 0};
      3'd7: return {15'd0, mOvf};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string addrTag(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd6: return "R10";
      3'd7: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(addrTag(regAddr), regRdData, modelWord(regAddr));
      chk("R10", {15'd0, irqOut}, {15'd0, mEn && (mq.size() > 0)});
    end
  end

  // Stimulus helpers: entered at posedge+2, leave at the next posedge+2
  task automatic step1();
    @(posedge clk); #2;
    capValid = 0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic setCap(input tbEnt_t e);
    capValid = 1; capDomain = e.dom; capMsgType = e.msg;
    capSeqId = e.seq; capNsec = e.ns; capSecLow = e.sec;
  endtask

  task automatic capture(input tbEnt_t e);
    setCap(e); step1();
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; step1();
  endtask

  task automatic stepAndCap(input tbEnt_t e);
    setCap(e); regWrEn = 1; regAddr = 3'd4; regWrData = 16'h0001; step1();
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [15:0] exp, input string tag);
    regAddr = a;
    @(negedge clk);
    chk(tag, regRdData, exp);
    @(posedge clk); #2;
  endtask

  task automatic expectIrq(input bit exp, input string tag);
    @(negedge clk);
    chk(tag, {15'd0, irqOut}, {15'd0, exp});
    @(posedge clk); #2;
  endtask

  function automatic tbEnt_t mk(input logic [15:0] seq);
    return '{dom: seq[7:0] ^ 8'h3C, msg: seq[3:0], seq: seq, ns: {14'h1A5, seq}, sec: seq[4:0]};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tbEnt_t a;
    rstN = 0; capValid = 0; capSecLow = '0; capNsec = '0; capDomain = '0;
    capMsgType = '0; capSeqId = '0; regWrEn = 0; regAddr = '0; regWrData = '0;
    repeat (5) @(posedge clk);
    #2 rstN = 1;
    step1();

    // R1: reset state
    for (int i = 0; i < 8; i++) expectReg(3'(i), 16'h0000, "R1");
    expectIrq(0, "R1");

    // R2 R3 R4 R5 R10: one record, field layout
    writeReg(3'd5, 16'h0001);
    expectReg(3'd5, 16'h0001, "R11");
    a = '{dom: 8'h5A, msg: 4'h3, seq: 16'hBEEF, ns: 30'h23456789, sec: 5'h1D};
    capture(a);
    expectIrq(1, "R10");
    expectReg(3'd6, 16'h0001, "R10");
    expectReg(3'd0, 16'h0000, "R5");
    writeReg(3'd0, 16'hFFFF);
    expectReg(3'd0, 16'h0000, "R11");
    writeReg(3'd4, 16'h0001);
    expectReg(3'd0, 16'hF35A, "R2");
    expectReg(3'd1, 16'hBEEF, "R3");
    expectReg(3'd2, 16'h6789, "R3");
    expectReg(3'd3, 16'h6345, "R4");
    expectReg(3'd4, 16'h0000, "R11");
    expectIrq(0, "R10");

    // R6: step with bit 0 clear is ignored; step on empty clears
    capture(mk(16'h0042));
    writeReg(3'd4, 16'hFFFE);
    expectReg(3'd1, 16'hBEEF, "R6");
    writeReg(3'd4, 16'h0001);
    expectReg(3'd1, 16'h0042, "R5");
    writeReg(3'd4, 16'h0001);
    expectReg(3'd0, 16'h0000, "R6");
    expectReg(3'd3, 16'h0000, "R6");

    // R7: fill past depth, ninth is dropped; R5 order
    for (int i = 0; i < DEPTH + 1; i++) capture(mk(16'h0100 + 16'(i)));
    expectReg(3'd7, 16'h0001, "R7");
    for (int i = 0; i < DEPTH; i++) begin
      writeReg(3'd4, 16'h0001);
      expectReg(3'd1, 16'h0100 + 16'(i), "R5");
    end
    writeReg(3'd4, 16'h0001);
    expectReg(3'd1, 16'h0000, "R7");
    // R8: sticky until cleared
    writeReg(3'd7, 16'h0000);
    expectReg(3'd7, 16'h0001, "R8");
    writeReg(3'd7, 16'h0001);
    expectReg(3'd7, 16'h0000, "R8");

    // R9: same-cycle capture and step at full and at empty
    for (int i = 0; i < DEPTH; i++) capture(mk(16'h0200 + 16'(i)));
    stepAndCap(mk(16'h02FF));
    expectReg(3'd1, 16'h0200, "R9");
    expectReg(3'd7, 16'h0000, "R9");
    for (int i = 1; i < DEPTH; i++) writeReg(3'd4, 16'h0001);
    writeReg(3'd4, 16'h0001);
    expectReg(3'd1, 16'h02FF, "R9");
    expectReg(3'd6, 16'h0000, "R9");
    stepAndCap(mk(16'h03AB));
    expectReg(3'd0, 16'h0000, "R9");
    expectReg(3'd6, 16'h0001, "R9");
    writeReg(3'd4, 16'h0001);
    expectReg(3'd1, 16'h03AB, "R9");

    // R10: disabled interrupt, status still visible; held with no ack
    writeReg(3'd5, 16'h0000);
    capture(mk(16'h0500));
    capture(mk(16'h0501));
    expectIrq(0, "R10");
    expectReg(3'd6, 16'h0001, "R10");
    writeReg(3'd5, 16'h0001);
    repeat (3) expectIrq(1, "R10");
    writeReg(3'd4, 16'h0001);
    expectIrq(1, "R10");
    writeReg(3'd4, 16'h0001);
    expectIrq(0, "R10");

    // Random mix, checked by the model every clock
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      capValid = (r < 40);
      capDomain = 8'($urandom); capMsgType = 4'($urandom); capSeqId = 16'($urandom);
      capNsec = 30'($urandom); capSecLow = 5'($urandom);
      regWrEn = ($urandom_range(0, 99) < 40);
      regAddr = 3'($urandom);
      regWrData = 16'($urandom);
      @(posedge clk); #2;
    end
    capValid = 0; regWrEn = 0;
    step1();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule